// File: doc/BRIEF.md
# Display Segment Pointer Writer

This block is a fixed-sequence master for a two-wire open-drain serial bus. On a start pulse it places an 8-bit segment index into a display device's extended identification memory by sending the segment-pointer device address (write direction) followed by the segment number. It drives each line only by pulling it low. A released line floats high and is read back through a synchronizer, so the block can see a slave that holds the clock low or acknowledges a byte.

The block does not end the transfer with a STOP. It leaves both lines released so that a separate bus master can continue with a repeated START and read the selected segment. All timing is counted in system clock cycles: one half bit period is `HALF_CYC` cycles (500 at 100 MHz gives 5 us). The clock-hold watch retries `POLL_TRIES` times, each one a full bit period, before it gives up.

Top module: `seg_ptr_writer`

## Requirements
- R1: After reset both drive-low outputs are 0 (lines released) and `done` and `error` are 0.
- R2: A transfer begins with a bus reset and then a START. The bus reset pulls SCL low, then SDA low, then releases SCL and then SDA. The START is SDA falling while SCL is high, followed by SCL going low.
- R3: Two bytes are shifted out MSB first, each bit sampled by the receiver on SCL rising: first 8'h60 (7-bit address 7'h30 with write bit 0 in bit 0), then the segment number.
- R4: SDA changes only while SCL is low. Without clock holding, SCL stays low for 2*HALF_CYC cycles between data bits and stays high for SETTLE_CYC + 2*HALF_CYC cycles per bit.
- R5: On the ninth clock of each byte SDA is released and sampled once SCL has been high for a settle plus a half period. A low level is an acknowledge.
- R6: A missing acknowledge on the first byte ends the transfer with `error` and the second byte is never sent. A missing acknowledge on the second byte also ends it with `error`.
- R7: After each SCL release the synchronized SCL is read SETTLE_CYC cycles later and then once every 2*HALF_CYC cycles. The half period that follows begins only once SCL reads high, so a slave may hold the clock low for a while without failing the transfer.
- R8: If SCL still reads low after POLL_TRIES retries, `error` rises SETTLE_CYC + POLL_TRIES*2*HALF_CYC cycles after the release and both lines are released.
- R9: At the end SDA is released while SCL is low, then SCL is released. No STOP condition appears, and `done` rises with both lines released.
- R10: `done` and `error` are single-cycle pulses and never high together.
- R11: A start pulse while a transfer runs is ignored. The segment number is captured at the accepted start, so later changes on `seg_num` have no effect.
- R12: A start in the cycle where `done` or `error` is high is accepted and begins a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to begin a transfer |
| seg_num | input | 8 | Segment index to send |
| scl_in | input | 1 | Level read back from the SCL line |
| sda_in | input | 1 | Level read back from the SDA line |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| done | output | 1 | Pulse: transfer finished with both bytes acknowledged |
| error | output | 1 | Pulse: missing acknowledge or clock-hold timeout |

## Verification
Two events can fall in the same cycle: the completion pulse of one transfer and the start request of the next. The bench issues every transfer after the first in the very cycle that `done` or `error` is seen high. It then judges the new transfer on its own bus reset, START, bytes and outcome. A second overlap is a start pulse that lands in the middle of a running transfer together with a changed segment number. The bench checks that the bytes on the bus still carry the originally captured segment and that only one completion follows.

// File: rtl/segw_pkg.sv
package segw_pkg;

    localparam logic [6:0] SEG_PTR_ADDR = 7'h30;
    localparam int         SLOT_BITS    = 9;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_START,
        PH_BYTE,
        PH_TAIL
    } phase_e;

    typedef enum logic [1:0] {
        WT_OFF,
        WT_SETTLE,
        WT_RETRY,
        WT_HALF
    } wait_e;

    typedef struct packed {
        logic scl_rel;
        logic sda_rel;
        logic chk;
    } step_t;

    function automatic logic [7:0] addr_byte();
        return {SEG_PTR_ADDR, 1'b0};
    endfunction

    function automatic logic [2:0] last_sub(phase_e ph);
        case (ph)
            PH_PRE:   return 3'd4;
            PH_START: return 3'd1;
            PH_BYTE:  return 3'd3;
            PH_TAIL:  return 3'd1;
            default:  return 3'd0;
        endcase
    endfunction

    // Line levels and clock-hold check for each micro-step of the sequence.
    function automatic step_t step_for(phase_e ph, logic [2:0] sub, logic dbit);
        step_t s;
        s.scl_rel = 1'b1;
        s.sda_rel = 1'b1;
        s.chk     = 1'b0;
        case (ph)
            PH_PRE: begin
                case (sub)
                    3'd0:    begin s.scl_rel = 1'b0; s.sda_rel = 1'b1; end
                    3'd1:    begin s.scl_rel = 1'b0; s.sda_rel = 1'b0; end
                    3'd2:    begin s.scl_rel = 1'b1; s.sda_rel = 1'b0; s.chk = 1'b1; end
                    default: begin s.scl_rel = 1'b1; s.sda_rel = 1'b1; end
                endcase
            end
            PH_START: begin
                s.sda_rel = 1'b0;
                s.scl_rel = (sub == 3'd0);
            end
            PH_BYTE: begin
                s.sda_rel = dbit;
                case (sub)
                    3'd1:    begin s.scl_rel = 1'b1; s.chk = 1'b1; end
                    3'd2:    s.scl_rel = 1'b1;
                    default: s.scl_rel = 1'b0;
                endcase
            end
            PH_TAIL: begin
                s.sda_rel = 1'b1;
                s.scl_rel = (sub != 3'd0);
                s.chk     = (sub != 3'd0);
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/segw_sync.sv
module segw_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RST_VAL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/segw_timer.sv
module segw_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);
    logic [CW-1:0] cnt;
    logic          run;

    assign expire = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (load) begin
            cnt <= load_val;
            run <= 1'b1;
        end else if (expire) begin
            run <= 1'b0;
        end else if (run) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/segw_bytes.sv
module segw_bytes
    import segw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] seg_in,
    input  logic       adv,
    output logic       cur_bit,
    output logic       ack_slot,
    output logic       last_slot,
    output logic [7:0] seg_q
);
    localparam logic [3:0] ACK_IDX = 4'(SLOT_BITS - 1);

    logic       byte_sel;
    logic [3:0] bit_idx;
    logic [7:0] cur_byte;
    logic [2:0] pos;

    assign cur_byte  = byte_sel ? seg_q : addr_byte();
    assign pos       = 3'd7 - bit_idx[2:0];
    assign ack_slot  = (bit_idx == ACK_IDX);
    assign last_slot = ack_slot && byte_sel;
    assign cur_bit   = ack_slot ? 1'b1 : cur_byte[pos];

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_sel <= 1'b0;
            bit_idx  <= '0;
            seg_q    <= '0;
        end else if (load) begin
            byte_sel <= 1'b0;
            bit_idx  <= '0;
            seg_q    <= seg_in;
        end else if (adv) begin
            if (ack_slot) begin
                bit_idx  <= '0;
                byte_sel <= 1'b1;
            end else begin
                bit_idx  <= bit_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/segw_seq.sv
module segw_seq
    import segw_pkg::*;
#(
    parameter int HALF_CYC   = 500,
    parameter int SETTLE_CYC = 4,
    parameter int POLL_TRIES = 100,
    parameter int CW         = 10,
    parameter int TW         = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          cur_bit,
    input  logic          ack_slot,
    input  logic          last_slot,
    input  logic          tmr_expire,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          load_bytes,
    output logic          adv_bit,
    output logic          scl_low,
    output logic          sda_low,
    output logic          done,
    output logic          error,
    output logic          busy,
    output logic          in_byte
);
    localparam logic [CW-1:0] HALF_M1   = CW'(HALF_CYC - 1);
    localparam logic [CW-1:0] SETTLE_M1 = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] RETRY_M1  = CW'(2 * HALF_CYC - 1);
    localparam logic [TW-1:0] TRY_LIM   = TW'(POLL_TRIES);

    phase_e        phase_q;
    logic [2:0]    sub_q;
    wait_e         wt_q;
    logic [TW-1:0] tries_q;
    logic          done_q, err_q;

    step_t      cur_step;
    phase_e     nph;
    logic [2:0] nsub;
    logic       want_adv, fin, next_chk;
    logic       idle, chk_eval, high_ok, timeout, retry, step_end, nack, enter;

    assign idle     = (phase_q == PH_IDLE);
    assign busy     = !idle;
    assign in_byte  = (phase_q == PH_BYTE);
    assign cur_step = step_for(phase_q, sub_q, cur_bit);
    assign scl_low  = busy && !cur_step.scl_rel;
    assign sda_low  = busy && !cur_step.sda_rel;
    assign done     = done_q;
    assign error    = err_q;

    assign chk_eval = tmr_expire && ((wt_q == WT_SETTLE) || (wt_q == WT_RETRY));
    assign high_ok  = chk_eval && scl_s;
    assign timeout  = chk_eval && !scl_s && (tries_q == TRY_LIM);
    assign retry    = chk_eval && !scl_s && (tries_q != TRY_LIM);
    assign step_end = tmr_expire && (wt_q == WT_HALF) && busy;
    assign nack     = step_end && in_byte && (sub_q == 3'd1) && ack_slot && sda_s;

    always_comb begin
        nph      = phase_q;
        nsub     = sub_q + 3'd1;
        want_adv = 1'b0;
        fin      = 1'b0;
        if (idle) begin
            nph  = PH_PRE;
            nsub = 3'd0;
        end else if (sub_q == last_sub(phase_q)) begin
            nsub = 3'd0;
            case (phase_q)
                PH_PRE:   nph = PH_START;
                PH_START: nph = PH_BYTE;
                PH_BYTE: begin
                    if (ack_slot && last_slot) nph = PH_TAIL;
                    else                       want_adv = 1'b1;
                end
                PH_TAIL:  fin = 1'b1;
                default:  ;
            endcase
        end
    end

    assign next_chk   = step_for(nph, nsub, 1'b0).chk;
    assign enter      = (idle && start) || (step_end && !fin && !nack);
    assign load_bytes = idle && start;
    assign adv_bit    = step_end && want_adv && !nack;
    assign tmr_load   = enter || high_ok || retry;

    always_comb begin
        if (enter)        tmr_val = next_chk ? SETTLE_M1 : HALF_M1;
        else if (high_ok) tmr_val = HALF_M1;
        else              tmr_val = RETRY_M1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            sub_q   <= '0;
            wt_q    <= WT_OFF;
            tries_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (idle) begin
                if (start) begin
                    phase_q <= nph;
                    sub_q   <= nsub;
                    wt_q    <= next_chk ? WT_SETTLE : WT_HALF;
                    tries_q <= '0;
                end
            end else if (timeout || nack) begin
                phase_q <= PH_IDLE;
                sub_q   <= '0;
                wt_q    <= WT_OFF;
                err_q   <= 1'b1;
            end else if (step_end && fin) begin
                phase_q <= PH_IDLE;
                sub_q   <= '0;
                wt_q    <= WT_OFF;
                done_q  <= 1'b1;
            end else if (step_end) begin
                phase_q <= nph;
                sub_q   <= nsub;
                wt_q    <= next_chk ? WT_SETTLE : WT_HALF;
                tries_q <= '0;
            end else if (high_ok) begin
                wt_q    <= WT_HALF;
            end else if (retry) begin
                wt_q    <= WT_RETRY;
                tries_q <= tries_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/seg_ptr_writer.sv
module seg_ptr_writer
    import segw_pkg::*;
#(
    parameter int HALF_CYC    = 500,
    parameter int SETTLE_CYC  = 4,
    parameter int POLL_TRIES  = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] seg_num,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_low,
    output logic       sda_low,
    output logic       done,
    output logic       error
);
    localparam int CW = $clog2(2 * HALF_CYC + SETTLE_CYC + 1);
    localparam int TW = $clog2(POLL_TRIES + 1);

    logic          scl_s, sda_s;
    logic          tmr_load, tmr_expire;
    logic [CW-1:0] tmr_val;
    logic          load_bytes, adv_bit;
    logic          cur_bit, ack_slot, last_slot;
    logic [7:0]    seg_q;
    logic          busy, in_byte;

    segw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
        .clk(clk), .rst(rst), .d(scl_in), .q(scl_s)
    );

    segw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
        .clk(clk), .rst(rst), .d(sda_in), .q(sda_s)
    );

    segw_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expire(tmr_expire)
    );

    segw_bytes u_bytes (
        .clk(clk), .rst(rst), .load(load_bytes), .seg_in(seg_num), .adv(adv_bit),
        .cur_bit(cur_bit), .ack_slot(ack_slot), .last_slot(last_slot), .seg_q(seg_q)
    );

    segw_seq #(
        .HALF_CYC(HALF_CYC), .SETTLE_CYC(SETTLE_CYC), .POLL_TRIES(POLL_TRIES),
        .CW(CW), .TW(TW)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .scl_s(scl_s), .sda_s(sda_s),
        .cur_bit(cur_bit), .ack_slot(ack_slot), .last_slot(last_slot),
        .tmr_expire(tmr_expire), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .load_bytes(load_bytes), .adv_bit(adv_bit),
        .scl_low(scl_low), .sda_low(sda_low), .done(done), .error(error),
        .busy(busy), .in_byte(in_byte)
    );
endmodule

// File: rtl/seg_ptr_writer_chk.sv
module seg_ptr_writer_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       scl_low,
    input logic       sda_low,
    input logic       done,
    input logic       error,
    input logic       busy,
    input logic       in_byte,
    input logic [7:0] seg_q
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R10

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        error |=> !error);  // R10

    AST_DONE_ERR_APART: assert property (@(posedge clk) disable iff (rst)
        !(done && error));  // R10

    AST_END_LINES_FREE: assert property (@(posedge clk) disable iff (rst)
        (done || error) |-> (!scl_low && !sda_low));  // R9

    AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (in_byte && $past(in_byte) && !scl_low && $past(!scl_low)) |-> $stable(sda_low));  // R4

    AST_SEG_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(seg_q));  // R11
endmodule

bind seg_ptr_writer seg_ptr_writer_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .scl_low(scl_low), .sda_low(sda_low),
    .done(done), .error(error), .busy(busy), .in_byte(in_byte), .seg_q(seg_q)
);

// File: tb/tb_seg_ptr_writer.sv
module tb_seg_ptr_writer;
    localparam int HALF   = 8;
    localparam int SETTLE = 3;
    localparam int TRIES  = 4;
    localparam int SYNC   = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] seg = 8'h00;
    logic       scl_low, sda_low, done, error;
    logic       slv_scl_low = 1'b0;
    logic       slv_sda_low = 1'b0;
    logic       scl_line, sda_line;

    assign scl_line = !(scl_low || slv_scl_low);
    assign sda_line = !(sda_low || slv_sda_low);

    always #5 clk = ~clk;

    seg_ptr_writer #(
        .HALF_CYC(HALF), .SETTLE_CYC(SETTLE), .POLL_TRIES(TRIES), .SYNC_STAGES(SYNC)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .seg_num(seg),
        .scl_in(scl_line), .sda_in(sda_line),
        .scl_low(scl_low), .sda_low(sda_low), .done(done), .error(error)
    );

    int checks = 0;
    int bad    = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard queues filled by the driver
    logic [7:0] exp_bytes[$];
    bit         exp_ok[$];
    string      exp_req[$];

    bit ack0 = 1'b1;
    bit ack1 = 1'b1;
    int smode = 0;
    int xfer_id = 0;

    // monitor / slave model
    int         seen_id = 0;
    bit         in_xfer = 0;
    int         bitcnt = 0, bytenum = 0;
    logic [7:0] sh = 8'h00;
    logic [7:0] e;
    bit         pscl = 1, psda = 1, pdone = 0, perr = 0;
    int         starts = 0, stops = 0;
    bit         saw_low = 0;
    int         lvl_cnt = 0;
    int         hold_cnt = 0;
    bit         hold_forever = 0;
    int         to_cnt = 0;
    bit         o;
    string      r;

    always @(negedge clk) begin
        logic s_scl, s_sda;
        s_scl = scl_line;
        s_sda = sda_line;
        if (!rst) begin
            if (xfer_id != seen_id) begin
                seen_id = xfer_id;
                in_xfer = 0; bitcnt = 0; bytenum = 0;
                starts = 0; stops = 0; saw_low = 0;
            end
            if (!in_xfer && !s_scl && !s_sda) saw_low = 1;
            if (pscl && s_scl && psda && !s_sda) begin
                starts++; in_xfer = 1; bitcnt = 0; bytenum = 0;
            end
            if (in_xfer && pscl && s_scl && !psda && s_sda) stops++;
            if (in_xfer && !pscl && s_scl) begin
                if (smode == 0 && bitcnt >= 1 && bitcnt <= 7)
                    chk(lvl_cnt == 2*HALF, "R4", "scl low cycles", lvl_cnt, 2*HALF);
                if (bitcnt < 8) sh = {sh[6:0], s_sda};
                bitcnt++;
                if (bitcnt == 8) begin
                    if (exp_bytes.size() == 0) chk(0, "R3", "unexpected byte", sh, 0);
                    else begin
                        e = exp_bytes.pop_front();
                        chk(sh == e, "R3", "byte on bus", sh, e);
                    end
                end
            end
            if (in_xfer && pscl && !s_scl) begin
                if (smode == 0 && bitcnt >= 1 && bitcnt <= 9)
                    chk(lvl_cnt == SETTLE + 2*HALF, "R4", "scl high cycles", lvl_cnt, SETTLE + 2*HALF);
                if (bitcnt == 8) slv_sda_low = (bytenum == 0) ? ack0 : ack1;
                else if (bitcnt == 9) begin
                    slv_sda_low = 1'b0; bitcnt = 0; bytenum++;
                end
                if (bytenum == 0 && bitcnt == 3 && smode == 1) hold_cnt = 30;
                if (bytenum == 0 && bitcnt == 3 && smode == 2) hold_forever = 1;
            end
            if (hold_forever && !scl_low && !s_scl && !error) to_cnt++;
            if (done && pdone) chk(0, "R10", "done longer than one cycle", 2, 1);
            if (error && perr) chk(0, "R10", "error longer than one cycle", 2, 1);
            if (done || error) begin
                chk(!(done && error), "R10", "done and error together", {done, error}, 0);
                if (exp_ok.size() == 0) chk(0, "R10", "unexpected completion", done, 0);
                else begin
                    o = exp_ok.pop_front();
                    r = exp_req.pop_front();
                    chk(done == o, r, "outcome done", done, o);
                end
                chk(exp_bytes.size() == 0, "R3", "bytes missing", exp_bytes.size(), 0);
                exp_bytes.delete();
                if (done) begin
                    chk(starts == 1 && saw_low, "R2", "bus reset then one START", starts, 1);
                    chk(stops == 0, "R9", "stop conditions", stops, 0);
                    chk(s_scl && s_sda, "R9", "lines at done", {s_scl, s_sda}, 3);
                end
                if (error) begin
                    chk(!scl_low && !sda_low, "R8", "drives at error", {scl_low, sda_low}, 0);
                    if (hold_forever) begin
                        chk(to_cnt == SETTLE + TRIES*2*HALF, "R8", "timeout cycles",
                            to_cnt, SETTLE + TRIES*2*HALF);
                        hold_forever = 0;
                        to_cnt = 0;
                    end
                end
                slv_sda_low = 1'b0;
            end
            if (s_scl == pscl) lvl_cnt++;
            else               lvl_cnt = 1;
            slv_scl_low = (hold_cnt > 0) || hold_forever;
            if (hold_cnt > 0) hold_cnt--;
        end
        pscl  = s_scl;
        psda  = s_sda;
        pdone = done;
        perr  = error;
    end

    // driver: pushes expectations, issues the request, waits for the outcome
    task automatic run_xfer(input logic [7:0] s, input bit a0, input bit a1,
                            input int mode, input string req, input bit poke);
        #1;
        if (mode != 2) begin
            exp_bytes.push_back(8'h60);
            if (a0) exp_bytes.push_back(s);
        end
        exp_ok.push_back(a0 && a1 && (mode != 2));
        exp_req.push_back(req);
        ack0 = a0; ack1 = a1; smode = mode;
        seg = s; start = 1'b1; xfer_id++;
        @(negedge clk); #1 start = 1'b0;
        if (poke) begin
            repeat (120) @(negedge clk);
            #1 seg = 8'hEE; start = 1'b1;
            @(negedge clk); #1 start = 1'b0;
        end
        do @(negedge clk); while (!(done || error));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!scl_low && !sda_low && !done && !error, "R1", "outputs after reset",
            {scl_low, sda_low, done, error}, 0);
        run_xfer(8'h00, 1, 1, 0, "R3",  0);
        run_xfer(8'hA5, 1, 1, 0, "R12", 0);
        run_xfer(8'h5A, 1, 1, 1, "R7",  0);
        run_xfer(8'h3C, 0, 1, 0, "R6",  0);
        run_xfer(8'hC3, 1, 0, 0, "R5",  0);
        run_xfer(8'h7F, 1, 1, 2, "R8",  0);
        run_xfer(8'h12, 1, 1, 0, "R11", 1);
        run_xfer(8'hFF, 1, 1, 0, "R12", 0);
        repeat (20) @(negedge clk);
        chk(exp_ok.size() == 0, "R10", "outcomes outstanding", exp_ok.size(), 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d cycles", 150000, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule